// File: doc/BRIEF.md
# Serial Shift Port with Edge-Delayed Capture

This block moves bytes between a parallel register and a two-wire serial link made of a count line and a data line. It runs entirely in the bus clock domain. When the direction bit selects receive, the block watches the count line through a synchronizer. It captures the data line a fixed number of clock cycles after each count rising edge and assembles eight captured bits into a byte. The finished byte is copied to the readable data register, and a one-cycle interrupt pulse is raised.

When the direction bit selects transmit, the block drives the count line itself. Each pulse on the timer-underflow strobe input toggles the count line once. The byte in the transmit buffer goes out most significant bit first, with each bit valid on the data line when the count line rises. A byte written while another is still shifting waits in the buffer and follows it with no gap. Changing the direction bit puts both the receiver and the transmitter back in their idle states. The timer that produces the strobe and the interrupt controller that consumes the pulse are outside the block.

The receiver has two states. RX_IDLE goes to RX_WAIT when a count rising edge is seen. RX_WAIT goes back to RX_IDLE in two cases: when the capture delay runs out, which captures a bit, or when another count rising edge arrives first, which abandons the bit. The transmitter has three states. TX_IDLE goes to TX_LOW on a strobe while the buffer holds a byte. TX_LOW goes to TX_HIGH on a strobe. On a strobe, TX_HIGH goes to one of three places: to TX_LOW for the next bit, to TX_LOW with a fresh byte after the eighth bit when the buffer is full, or to TX_IDLE after the eighth bit when the buffer is empty.

Top module: `serial_shift_port`

## Requirements
- R1: While rst_n is low at a clock edge, the block clears data_o to 0, sets cnt_o and sp_o high, clears irq_o and selects receive mode (out_en_o low).
- R2: In receive mode, let P0 be the clock edge that first registers cnt_i high after it was low. The bit taken is the sp_i value present at clock edge P0+SAMPLE_LAT (default 3).
- R3: Received bits are shifted in so that the first bit of a byte ends up as bit 7. After the eighth bit, the byte appears on data_o and irq_o is high for exactly one cycle, in the same cycle.
- R4: If a second cnt_i rising edge is detected before a pending capture completes, the pending bit is abandoned. That second edge does not start a new capture either.
- R5: cnt_i returning low before the capture point does not cancel the pending capture.
- R6: Any change of dir_out_i clears the receive bit count and shift state and returns the transmitter to idle with an empty buffer. A partial byte therefore never appears.
- R7: In transmit mode, cnt_o changes only in the cycle after a tmr_uf_i strobe and toggles at most once per strobe. Each bit is valid on sp_o when cnt_o rises, most significant bit first.
- R8: A byte written (wr_en_i) in transmit mode while another byte is shifting is sent right after it. With a strobe every 2 cycles, cnt_o rising edges stay exactly 4 cycles apart across the byte boundary.
- R9: In transmit mode, irq_o pulses once per transmitted byte, after the high phase of its eighth bit.
- R10: out_en_o follows dir_out_i one cycle later. In receive mode cnt_o stays high whatever tmr_uf_i does.
- R11: data_o changes only in the cycle after a wr_en_i write, which stores wr_data_i in either mode, or together with a receive irq_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_out_i | input | 1 | Direction: 1 transmit, 0 receive |
| wr_en_i | input | 1 | Write strobe for the data register |
| wr_data_i | input | DATA_W | Write data |
| tmr_uf_i | input | 1 | Timer underflow strobe, one toggle of cnt_o per pulse |
| cnt_i | input | 1 | Count line from the far end |
| sp_i | input | 1 | Serial data line from the far end |
| data_o | output | DATA_W | Readable data register |
| cnt_o | output | 1 | Count line driven in transmit mode |
| sp_o | output | 1 | Serial data line driven in transmit mode |
| out_en_o | output | 1 | High when the block drives cnt_o and sp_o |
| irq_o | output | 1 | One-cycle pulse per completed byte |

## Verification
The assertions check several rules on every cycle: the reset values, the single-cycle interrupt pulse, that cnt_o stays high in receive mode and changes only after a strobe, that out_en_o tracks the direction bit, and that data_o changes only after a write or a completed byte. Other behaviours need stimulus arranged around them, so only the bench scenarios can show them. These are the exact capture edge after a count rise, the abandoning of a bit by a quick second edge, survival of a short count pulse, the discarding of a partial byte on a direction change, bit order, and gap-free transmission of a buffered byte.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    typedef enum logic [0:0] {RX_IDLE, RX_WAIT} rx_state_t;
    typedef enum logic [1:0] {TX_IDLE, TX_LOW, TX_HIGH} tx_state_t;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d_i[g]};
            end
            assign q_o[g] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx
    import ssp_pkg::*;
#(
    parameter int BITS = 8,
    parameter int LAT  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            cnt_s,
    input  logic            sp_s,
    output logic            done_o,
    output logic [BITS-1:0] byte_o
);
    localparam int CW = $clog2(BITS + 1);
    localparam int LW = $clog2(LAT + 1);

    rx_state_t       state, state_nx;
    logic            cnt_d;
    logic [LW-1:0]   pend;
    logic [BITS-1:0] sh;
    logic [CW-1:0]   nbits;
    logic            rise, fire;

    assign rise = cnt_s & ~cnt_d;
    assign fire = (state == RX_WAIT) && !rise && (pend == LW'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) state <= RX_IDLE;
        else               state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE: if (rise) state_nx = RX_WAIT;
            RX_WAIT: begin
                if (rise)                   state_nx = RX_IDLE; // abandon
                else if (pend == LW'(1))    state_nx = RX_IDLE; // capture
            end
            default: state_nx = RX_IDLE;
        endcase
    end

    // datapath / outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_d <= 1'b0;
        end else begin
            cnt_d <= cnt_s;
        end
        if (!rst_n || clr) begin
            pend  <= '0;
            sh    <= '0;
            nbits <= '0;
        end else begin
            unique case (state)
                RX_IDLE: if (rise) pend <= LW'(LAT);
                RX_WAIT: pend <= rise ? '0 : pend - LW'(1);
                default: pend <= '0;
            endcase
            if (fire) begin
                sh    <= {sh[BITS-2:0], sp_s};
                nbits <= (nbits == CW'(BITS - 1)) ? '0 : nbits + CW'(1);
            end
        end
    end

    assign done_o = fire && (nbits == CW'(BITS - 1));
    assign byte_o = {sh[BITS-2:0], sp_s};
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx
    import ssp_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            en,
    input  logic            uf,
    input  logic            wr,
    input  logic [BITS-1:0] wdata,
    output logic            cnt_o,
    output logic            sp_o,
    output logic            done_o
);
    localparam int CW = $clog2(BITS + 1);

    tx_state_t       state, state_nx;
    logic [BITS-1:0] sh, hold;
    logic [CW-1:0]   nbits;
    logic            hold_full, cnt_q, sp_q, done_q;
    logic            go, last, load;

    assign go   = en & uf;
    assign last = (nbits == CW'(BITS));
    assign load = go && hold_full &&
                  ((state == TX_IDLE) || ((state == TX_HIGH) && last));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) state <= TX_IDLE;
        else               state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE: if (go && hold_full) state_nx = TX_LOW;
            TX_LOW:  if (go)              state_nx = TX_HIGH;
            TX_HIGH: if (go) state_nx = (last && !hold_full) ? TX_IDLE : TX_LOW;
            default: state_nx = TX_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q     <= 1'b1;
            sp_q      <= 1'b1;
            done_q    <= 1'b0;
            hold_full <= 1'b0;
            hold      <= '0;
            sh        <= '0;
            nbits     <= '0;
        end else begin
            done_q <= 1'b0;
            if (wr && en) begin
                hold      <= wdata;
                hold_full <= 1'b1;
            end else if (load) begin
                hold_full <= 1'b0;
            end
            if (load) begin
                cnt_q <= 1'b0;
                sp_q  <= hold[BITS-1];
                sh    <= {hold[BITS-2:0], 1'b0};
                nbits <= '0;
            end
            unique case (state)
                TX_IDLE: ;
                TX_LOW: if (go) begin
                    cnt_q <= 1'b1;
                    nbits <= nbits + CW'(1);
                end
                TX_HIGH: if (go) begin
                    if (last) begin
                        done_q <= 1'b1;
                    end else begin
                        cnt_q <= 1'b0;
                        sp_q  <= sh[BITS-1];
                        sh    <= {sh[BITS-2:0], 1'b0};
                    end
                end
                default: ;
            endcase
        end
    end

    assign cnt_o  = cnt_q;
    assign sp_o   = sp_q;
    assign done_o = done_q;
endmodule

// File: rtl/serial_shift_port.sv
module serial_shift_port #(
    parameter int DATA_W      = 8,
    parameter int SAMPLE_LAT  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_out_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              tmr_uf_i,
    input  logic              cnt_i,
    input  logic              sp_i,
    output logic [DATA_W-1:0] data_o,
    output logic              cnt_o,
    output logic              sp_o,
    output logic              out_en_o,
    output logic              irq_o
);
    logic              mode_q, mode_chg;
    logic [1:0]        pins_s;
    logic              rx_done, tx_done, irq_q;
    logic [DATA_W-1:0] rx_byte, sdr_q;

    assign mode_chg = dir_out_i ^ mode_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            sdr_q  <= '0;
            irq_q  <= 1'b0;
        end else begin
            mode_q <= dir_out_i;
            irq_q  <= rx_done | tx_done;
            if (wr_en_i)      sdr_q <= wr_data_i;
            else if (rx_done) sdr_q <= rx_byte;
        end
    end

    ssp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i({cnt_i, sp_i}), .q_o(pins_s)
    );

    ssp_rx #(.BITS(DATA_W), .LAT(SAMPLE_LAT)) u_rx (
        .clk(clk), .rst_n(rst_n), .clr(mode_chg | mode_q),
        .cnt_s(pins_s[1]), .sp_s(pins_s[0]),
        .done_o(rx_done), .byte_o(rx_byte)
    );

    ssp_tx #(.BITS(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .clr(mode_chg), .en(mode_q),
        .uf(tmr_uf_i), .wr(wr_en_i), .wdata(wr_data_i),
        .cnt_o(cnt_o), .sp_o(sp_o), .done_o(tx_done)
    );

    assign data_o   = sdr_q;
    assign out_en_o = mode_q;
    assign irq_o    = irq_q;
endmodule

// File: rtl/ssp_chk.sv
module ssp_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dir_out_i,
    input logic              wr_en_i,
    input logic              tmr_uf_i,
    input logic [DATA_W-1:0] data_o,
    input logic              cnt_o,
    input logic              out_en_o,
    input logic              irq_o
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (cnt_o && !irq_o && !out_en_o && data_o == '0));

    // R3
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R10
    rx_cnt_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_o |-> cnt_o);

    // R10
    mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (out_en_o == $past(dir_out_i)));

    // R7
    toggle_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en_o && dir_out_i && !tmr_uf_i) |=> $stable(cnt_o));

    // R11
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_o) |-> (irq_o || $past(wr_en_i)));
endmodule

bind serial_shift_port ssp_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_serial_shift_port.sv
module sim_serial_shift_port;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir_out_i = 1'b0, wr_en_i = 1'b0, tmr_uf_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic       cnt_i = 1'b0, sp_i = 1'b0;
    logic [7:0] data_o;
    logic       cnt_o, sp_o, out_en_o, irq_o;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit finished = 0;
    bit uf_en = 0;

    logic [7:0] rxq[$];  string rxt[$];
    logic [7:0] txq[$];  string txt[$];
    int   tx_irqs = 0;
    bit   cont_chk = 0;
    int   rise_n = 0, last_rise = 0;
    logic cnt_prev = 1'b1;
    logic [7:0] tx_acc = '0;
    int   tx_bits = 0;

    always #(CLK_P/2) clk = ~clk;

    serial_shift_port u0 (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // strobe generator: one pulse every 2 cycles
    always @(negedge clk) tmr_uf_i <= uf_en ? ~tmr_uf_i : 1'b0;

    // monitor / scoreboard
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (irq_o && !out_en_o) begin
                if (rxq.size() == 0) check(0, "R3 unexpected byte", data_o, 0);
                else begin
                    logic [7:0] e; string t;
                    e = rxq.pop_front(); t = rxt.pop_front();
                    check(data_o == e, t, data_o, e);
                end
            end
            if (irq_o && out_en_o) tx_irqs++;
            if (out_en_o && cnt_o && !cnt_prev) begin
                if (cont_chk) begin
                    if (rise_n > 0) check(cyc - last_rise == 4, "R8 rise spacing", cyc - last_rise, 4);
                    rise_n++;
                end
                last_rise = cyc;
                tx_acc = {tx_acc[6:0], sp_o};
                tx_bits++;
                if (tx_bits == 8) begin
                    tx_bits = 0;
                    if (txq.size() == 0) check(0, "R7 unexpected tx byte", tx_acc, 0);
                    else begin
                        logic [7:0] e; string t;
                        e = txq.pop_front(); t = txt.pop_front();
                        check(tx_acc == e, t, tx_acc, e);
                    end
                end
            end
        end
        cnt_prev = cnt_o;
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rx_bit(input logic b);
        sp_i = b; cnt_i = 1'b1; step(4);
        cnt_i = 1'b0; step(4);
    endtask

    task automatic rx_byte(input logic [7:0] v, input string tag);
        rxq.push_back(v); rxt.push_back(tag);
        for (int i = 7; i >= 0; i--) rx_bit(v[i]);
    endtask

    // sp_i flips to ~v0 just before edge P0+k
    task automatic lat_bit(input int k, input logic v0);
        sp_i = v0; cnt_i = 1'b1; step(k);
        sp_i = ~v0;
        if (k < 4) step(4 - k);
        cnt_i = 1'b0; step(6);
    endtask

    task automatic short_bit(input logic b);
        sp_i = b; cnt_i = 1'b1; step(1);
        cnt_i = 1'b0; step(7);
    endtask

    task automatic wr(input logic [7:0] v);
        wr_data_i = v; wr_en_i = 1'b1; step(1); wr_en_i = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        check(0, "watchdog", cyc, 0);
        finish_run();
    end

    initial begin
        step(3);
        // R1 reset state
        check(data_o == 8'h00, "R1 data", data_o, 0);
        check(cnt_o == 1'b1, "R1 cnt_o", cnt_o, 1);
        check(sp_o == 1'b1, "R1 sp_o", sp_o, 1);
        check(irq_o == 1'b0, "R1 irq", irq_o, 0);
        check(out_en_o == 1'b0, "R1 out_en", out_en_o, 0);
        rst_n = 1'b1; step(3);

        // R2 capture edge: flip before P0+3 taken, flip before P0+4 not
        rxq.push_back(8'hAD); rxt.push_back("R2 capture edge");
        lat_bit(3, 1'b0);
        lat_bit(4, 1'b0);
        rx_bit(1); rx_bit(0); rx_bit(1); rx_bit(1); rx_bit(0); rx_bit(1);
        step(4);

        // R3 plain byte, MSB first
        rx_byte(8'h4E, "R3 assembly");
        step(4);

        // R4 quick second edge abandons the bit
        sp_i = 1'b1; cnt_i = 1'b1; step(1);
        cnt_i = 1'b0; step(1);
        cnt_i = 1'b1; step(1);
        cnt_i = 1'b0; step(8);
        rx_byte(8'h5A, "R4 abandon");
        step(4);

        // R5 one-cycle count pulse still captures
        rxq.push_back(8'hC3); rxt.push_back("R5 short pulse");
        for (int i = 7; i >= 0; i--) short_bit(8'hC3 >> i);
        step(4);

        // R6 direction change drops a partial byte
        rx_bit(1); rx_bit(1); rx_bit(1);
        dir_out_i = 1'b1; step(2);
        check(out_en_o == 1'b1, "R10 out_en follows", out_en_o, 1);
        dir_out_i = 1'b0; step(3);
        check(data_o == 8'hC3, "R11 no partial byte", data_o, 8'hC3);
        rx_byte(8'h96, "R6 counter cleared");
        step(4);

        // R10 strobes ignored in receive mode; R11 write in receive mode
        uf_en = 1;
        begin
            int bad = 0;
            for (int i = 0; i < 20; i++) begin step(1); if (!cnt_o) bad++; end
            check(bad == 0, "R10 cnt_o high in receive", bad, 0);
        end
        uf_en = 0; step(2);
        wr(8'h77);
        check(data_o == 8'h77, "R11 write stores", data_o, 8'h77);
        step(6);
        check(cnt_o == 1'b1, "R10 no tx in receive", cnt_o, 1);
        check(rxq.size() == 0, "R3 all bytes seen", rxq.size(), 0);

        // R7/R8 transmit with buffered second byte
        dir_out_i = 1'b1; step(2);
        uf_en = 1; rise_n = 0; cont_chk = 1;
        txq.push_back(8'h3C); txt.push_back("R7 tx byte");
        wr(8'h3C);
        step(8);
        txq.push_back(8'hA5); txt.push_back("R8 buffered byte");
        wr(8'hA5);
        for (int i = 0; i < 200 && rise_n < 16; i++) step(1);
        cont_chk = 0;
        check(rise_n == 16, "R8 rises in burst", rise_n, 16);
        step(40);

        // R9 single byte and interrupt count
        txq.push_back(8'h81); txt.push_back("R9 single byte");
        wr(8'h81);
        step(80);
        check(tx_irqs == 3, "R9 tx irq count", tx_irqs, 3);
        check(txq.size() == 0, "R7 all tx bytes seen", txq.size(), 0);
        check(cnt_o == 1'b1, "R7 idle high", cnt_o, 1);
        uf_en = 0; step(4);
        finish_run();
    end
endmodule